// File: doc/BRIEF.md
# Receive Packet Release Controller

This block sits between a UART receive buffer and a host-side packet engine and decides, for every read request the host makes, whether the buffered bytes go out now or the host is told to retry (NAK). A full packet is always released at once. A partial packet is held back until the serial line has been quiet for longer than a set number of character periods. This keeps packets large and cuts host overhead at high line rates.

At low line rates that idle wait can add too much latency. A low-latency mode therefore releases any non-empty buffer on the next request. The mode is entered through an explicit control bit. It is also entered on its own whenever the programmed line rate is below a configurable limit.

The block sees only status: the buffer fill count, a pulse for each received byte, a character-period tick, and the request strobe. Its response is a one-cycle accept or NAK pulse, issued one clock after the request. With each accept it latches the number of bytes to send.

Top module: `rx_release_ctrl`

## Requirements
- R1: When a request is sampled with a fill count of at least 64 (the packet size), `rel_ack` pulses one clock later and `rel_len` becomes exactly 64, whatever the idle state.
- R2: When a request is sampled with a fill count between 1 and 63, no idle timeout reached and low-latency mode off, `rel_nak` pulses one clock later.
- R3: The idle timeout is reached once more than 3 character ticks (that is, at least 4) have been seen since the last received byte. A partial-packet request sampled after that is accepted, and `rel_len` equals the fill count. After exactly 3 ticks the request is still answered with NAK.
- R4: With `lowlat_set` high, a request sampled with any fill count from 1 to 63 is accepted at once, with `rel_len` equal to the fill count.
- R5: A `baud_rate` below 40960 acts exactly as if `lowlat_set` were high. A `baud_rate` of 40960 or more leaves the mode governed by `lowlat_set` alone.
- R6: A request sampled with a fill count of 0 is always answered with NAK, whatever `lowlat_set`, `baud_rate` or the idle state.
- R7: Every `byte_rx` pulse restarts the idle measurement from zero. A `byte_rx` in the same cycle as `char_tick` also restarts it, and the tick is not counted.
- R8: Once reached, the idle timeout stays in force through any number of accepted requests and further ticks, until the next `byte_rx`.
- R9: `rel_ack` and `rel_nak` are one-cycle pulses that are never high together. Exactly one of them follows each sampled request, and neither appears without one. `rel_len` is loaded only on an accept and holds its value across NAKs and quiet cycles.
- R10: While `rst_n` is low, and right after reset, `rel_ack`, `rel_nak` and `rel_len` are 0 and the idle timeout is not in force.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fill_cnt | input | FILL_W (10) | Bytes currently held in the receive buffer |
| byte_rx | input | 1 | One-cycle pulse per byte written into the buffer |
| char_tick | input | 1 | One-cycle pulse per character period on the line |
| rd_req | input | 1 | One-cycle host read request |
| lowlat_set | input | 1 | Low-latency mode control bit |
| baud_rate | input | BAUD_W (24) | Programmed line rate in bits per second |
| rel_ack | output | 1 | Request accepted: send `rel_len` bytes |
| rel_nak | output | 1 | Request refused: data not ready |
| rel_len | output | LEN_W (7) | Byte count latched at the last accept |

## Verification
The bench builds the block with its defaults: a 64-byte packet, a 10-bit fill count, an idle threshold of 3 character periods, and automatic low-latency selection turned on. The 10-bit count lets fills well above the packet size be driven, so the cap at 64 is exercised, as are the 63 and 64 edges. An idle threshold of 3 needs only a handful of ticks, so the run covers both the 3-tick NAK and the 4-tick release. With automatic selection built in, the line-rate limit can be probed on both sides of 40960.

// File: rtl/rx_rel_pkg.sv
package rx_rel_pkg;

   typedef enum logic [1:0] {
      RSP_NONE = 2'd0,
      RSP_ACK  = 2'd1,
      RSP_NAK  = 2'd2
   } rsp_e;

   function automatic int unsigned bits_for(input int unsigned value);
      return (value < 2) ? 1 : $clog2(value + 1);
   endfunction

endpackage

// File: rtl/rx_rel_idle_timer.sv
module rx_rel_idle_timer #(
   parameter int unsigned IDLE_CHARS = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic byte_rx,
   input  logic char_tick,
   output logic idle_hit
);
   import rx_rel_pkg::*;

   localparam int unsigned SAT_VAL = IDLE_CHARS + 1;
   localparam int unsigned CNT_W   = bits_for(SAT_VAL);

   logic [CNT_W-1:0] tick_cnt;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         tick_cnt <= '0;
      end else if (byte_rx) begin
         tick_cnt <= '0;
      end else if (char_tick && (tick_cnt != CNT_W'(SAT_VAL))) begin
         tick_cnt <= tick_cnt + 1'b1;
      end
   end

   assign idle_hit = (tick_cnt == CNT_W'(SAT_VAL));

endmodule

// File: rtl/rx_rel_lowlat_sel.sv
module rx_rel_lowlat_sel #(
   parameter int unsigned BAUD_W      = 24,
   parameter bit          AUTO_LOWLAT = 1'b1,
   parameter int unsigned BAUD_LIMIT  = 40960
) (
   input  logic              lowlat_set,
   input  logic [BAUD_W-1:0] baud_rate,
   output logic              lowlat_eff
);

   generate
      if (AUTO_LOWLAT) begin : g_auto
         assign lowlat_eff = lowlat_set || (baud_rate < BAUD_W'(BAUD_LIMIT));
      end else begin : g_manual
         logic unused_baud;
         assign unused_baud = ^baud_rate;
         assign lowlat_eff  = lowlat_set;
      end
   endgenerate

endmodule

// File: rtl/rx_rel_decider.sv
module rx_rel_decider #(
   parameter int unsigned FILL_W    = 10,
   parameter int unsigned PKT_BYTES = 64,
   parameter int unsigned LEN_W     = 7
) (
   input  logic [FILL_W-1:0] fill_cnt,
   input  logic              idle_hit,
   input  logic              lowlat_eff,
   output logic              accept,
   output logic [LEN_W-1:0]  send_len
);

   logic has_data;
   logic full_pkt;

   always_comb begin
      has_data = (fill_cnt != '0);
      full_pkt = (fill_cnt >= FILL_W'(PKT_BYTES));
      accept   = has_data && (full_pkt || idle_hit || lowlat_eff);
      if (full_pkt) begin
         send_len = LEN_W'(PKT_BYTES);
      end else begin
         send_len = LEN_W'(fill_cnt);
      end
   end

endmodule

// File: rtl/rx_release_ctrl.sv
module rx_release_ctrl #(
   parameter int unsigned FILL_W      = 10,
   parameter int unsigned PKT_BYTES   = 64,
   parameter int unsigned IDLE_CHARS  = 3,
   parameter int unsigned BAUD_W      = 24,
   parameter bit          AUTO_LOWLAT = 1'b1,
   parameter int unsigned BAUD_LIMIT  = 40960,
   parameter int unsigned LEN_W       = rx_rel_pkg::bits_for(PKT_BYTES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [FILL_W-1:0] fill_cnt,
   input  logic              byte_rx,
   input  logic              char_tick,
   input  logic              rd_req,
   input  logic              lowlat_set,
   input  logic [BAUD_W-1:0] baud_rate,
   output logic              rel_ack,
   output logic              rel_nak,
   output logic [LEN_W-1:0]  rel_len
);
   import rx_rel_pkg::*;

   generate
      if (PKT_BYTES < 1) begin : g_bad_pkt
         $error("PKT_BYTES must be at least 1");
      end
      if (PKT_BYTES >= (1 << FILL_W)) begin : g_bad_fill
         $error("FILL_W too narrow for PKT_BYTES");
      end
      if (LEN_W < bits_for(PKT_BYTES)) begin : g_bad_len
         $error("LEN_W too narrow for PKT_BYTES");
      end
      if (AUTO_LOWLAT && (BAUD_LIMIT >= (64'd1 << BAUD_W))) begin : g_bad_baud
         $error("BAUD_W too narrow for BAUD_LIMIT");
      end
   endgenerate

   logic             idle_hit;
   logic             lowlat_eff;
   logic             accept;
   logic [LEN_W-1:0] send_len;
   rsp_e             rsp_q;

   rx_rel_idle_timer #(
      .IDLE_CHARS(IDLE_CHARS)
   ) u_idle (
      .clk      (clk),
      .rst_n    (rst_n),
      .byte_rx  (byte_rx),
      .char_tick(char_tick),
      .idle_hit (idle_hit)
   );

   rx_rel_lowlat_sel #(
      .BAUD_W     (BAUD_W),
      .AUTO_LOWLAT(AUTO_LOWLAT),
      .BAUD_LIMIT (BAUD_LIMIT)
   ) u_lowlat (
      .lowlat_set(lowlat_set),
      .baud_rate (baud_rate),
      .lowlat_eff(lowlat_eff)
   );

   rx_rel_decider #(
      .FILL_W   (FILL_W),
      .PKT_BYTES(PKT_BYTES),
      .LEN_W    (LEN_W)
   ) u_decide (
      .fill_cnt  (fill_cnt),
      .idle_hit  (idle_hit),
      .lowlat_eff(lowlat_eff),
      .accept    (accept),
      .send_len  (send_len)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rsp_q   <= RSP_NONE;
         rel_len <= '0;
      end else if (rd_req) begin
         rsp_q <= accept ? RSP_ACK : RSP_NAK;
         if (accept) begin
            rel_len <= send_len;
         end
      end else begin
         rsp_q <= RSP_NONE;
      end
   end

   assign rel_ack = (rsp_q == RSP_ACK);
   assign rel_nak = (rsp_q == RSP_NAK);

endmodule

// File: rtl/rx_release_ctrl_chk.sv
module rx_release_ctrl_chk #(
   parameter int unsigned FILL_W      = 10,
   parameter int unsigned PKT_BYTES   = 64,
   parameter int unsigned BAUD_W      = 24,
   parameter bit          AUTO_LOWLAT = 1'b1,
   parameter int unsigned BAUD_LIMIT  = 40960,
   parameter int unsigned LEN_W       = 7
) (
   input logic              clk,
   input logic              rst_n,
   input logic [FILL_W-1:0] fill_cnt,
   input logic              byte_rx,
   input logic              rd_req,
   input logic              lowlat_set,
   input logic [BAUD_W-1:0] baud_rate,
   input logic              idle_hit,
   input logic              rel_ack,
   input logic              rel_nak,
   input logic [LEN_W-1:0]  rel_len
);

   logic partial;
   assign partial = (fill_cnt != '0) && (fill_cnt < FILL_W'(PKT_BYTES));

   AST_ONE_RESPONSE: assert property (@(posedge clk) disable iff (!rst_n)
      rd_req |=> (rel_ack ^ rel_nak)); // R9
   AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_req |=> (!rel_ack && !rel_nak)); // R9
   AST_LEN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !rel_ack |-> $stable(rel_len)); // R9
   AST_FULL_PKT: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_req && (fill_cnt >= FILL_W'(PKT_BYTES))) |=> (rel_ack && (rel_len == LEN_W'(PKT_BYTES)))); // R1
   AST_EMPTY_NAK: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_req && (fill_cnt == '0)) |=> rel_nak); // R6
   AST_IDLE_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_req && idle_hit && partial) |=> (rel_ack && (rel_len == $past(LEN_W'(fill_cnt))))); // R3
   AST_LOWLAT_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_req && lowlat_set && partial) |=> rel_ack); // R4
   AST_AUTO_LOWLAT: assert property (@(posedge clk) disable iff (!rst_n)
      (AUTO_LOWLAT && rd_req && partial && (baud_rate < BAUD_W'(BAUD_LIMIT))) |=> rel_ack); // R5
   AST_FRESH_BYTE_NAK: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(byte_rx) && rd_req && partial && !lowlat_set &&
       (!AUTO_LOWLAT || (baud_rate >= BAUD_W'(BAUD_LIMIT)))) |=> rel_nak); // R2
   AST_BYTE_CLEARS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      byte_rx |=> !idle_hit); // R7
   AST_IDLE_PERSIST: assert property (@(posedge clk) disable iff (!rst_n)
      (idle_hit && !byte_rx) |=> idle_hit); // R8
   AST_RESET_QUIET: assert property (@(posedge clk)
      !rst_n |=> (!rel_ack && !rel_nak && (rel_len == '0) && !idle_hit)); // R10

endmodule

bind rx_release_ctrl rx_release_ctrl_chk #(
   .FILL_W     (FILL_W),
   .PKT_BYTES  (PKT_BYTES),
   .BAUD_W     (BAUD_W),
   .AUTO_LOWLAT(AUTO_LOWLAT),
   .BAUD_LIMIT (BAUD_LIMIT),
   .LEN_W      (LEN_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .fill_cnt  (fill_cnt),
   .byte_rx   (byte_rx),
   .rd_req    (rd_req),
   .lowlat_set(lowlat_set),
   .baud_rate (baud_rate),
   .idle_hit  (idle_hit),
   .rel_ack   (rel_ack),
   .rel_nak   (rel_nak),
   .rel_len   (rel_len)
);

// File: tb/tb_rx_release_ctrl.sv
module tb_rx_release_ctrl;

   localparam int FILL_W = 10;
   localparam int BAUD_W = 24;
   localparam int LEN_W  = 7;

   typedef struct {
      bit          ack;
      int unsigned len;
      string       tag;
   } exp_t;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic [FILL_W-1:0] fill_cnt = '0;
   logic              byte_rx = 1'b0;
   logic              char_tick = 1'b0;
   logic              rd_req = 1'b0;
   logic              lowlat_set = 1'b0;
   logic [BAUD_W-1:0] baud_rate = 24'd115200;
   logic              rel_ack;
   logic              rel_nak;
   logic [LEN_W-1:0]  rel_len;

   int   n_checks = 0;
   int   n_fail   = 0;
   bit   done     = 1'b0;
   bit   req_seen = 1'b0;
   int unsigned last_len = 0;
   exp_t exp_q[$];

   always #5 clk = ~clk;

   rx_release_ctrl dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .fill_cnt  (fill_cnt),
      .byte_rx   (byte_rx),
      .char_tick (char_tick),
      .rd_req    (rd_req),
      .lowlat_set(lowlat_set),
      .baud_rate (baud_rate),
      .rel_ack   (rel_ack),
      .rel_nak   (rel_nak),
      .rel_len   (rel_len)
   );

   // monitor: scoreboard pop and compare
   always @(posedge clk) req_seen <= rd_req;

   always @(negedge clk) begin
      if (rst_n && !done) begin
         if (req_seen) begin
            exp_t e;
            n_checks++;
            if (exp_q.size() == 0) begin
               n_fail++;
               $display("FAIL R9: response with no expected item ack=%0b nak=%0b", rel_ack, rel_nak);
            end else begin
               e = exp_q.pop_front();
               if (rel_ack !== e.ack || rel_nak !== !e.ack || rel_len !== LEN_W'(e.len)) begin
                  n_fail++;
                  $display("FAIL %s: ack=%0b nak=%0b len=%0d expected ack=%0b nak=%0b len=%0d",
                           e.tag, rel_ack, rel_nak, rel_len, e.ack, !e.ack, e.len);
               end
            end
         end else if (rel_ack || rel_nak) begin
            n_checks++;
            n_fail++;
            $display("FAIL R9: pulse without request ack=%0b nak=%0b expected ack=0 nak=0", rel_ack, rel_nak);
         end
      end
   end

   // driver tasks
   task automatic request(input bit exp_ack, input int unsigned exp_len, input string tag);
      exp_t e;
      @(negedge clk);
      if (exp_ack) last_len = exp_len;
      e.ack = exp_ack;
      e.len = exp_ack ? exp_len : last_len;
      e.tag = tag;
      exp_q.push_back(e);
      rd_req = 1'b1;
      @(negedge clk);
      rd_req = 1'b0;
   endtask

   task automatic rx_byte(input int unsigned new_fill);
      @(negedge clk);
      fill_cnt = FILL_W'(new_fill);
      byte_rx  = 1'b1;
      @(negedge clk);
      byte_rx  = 1'b0;
   endtask

   task automatic ticks(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         char_tick = 1'b1;
         @(negedge clk);
         char_tick = 1'b0;
      end
   endtask

   task automatic direct_check(input bit ok, input string what);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: ack=%0b nak=%0b len=%0d expected ack=0 nak=0 len=%0d",
                  what, rel_ack, rel_nak, rel_len, last_len);
      end
   endtask

   task automatic finish_run();
      done = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   endtask

   // watchdog
   initial begin
      repeat (20000) @(posedge clk);
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=done");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      direct_check(!rel_ack && !rel_nak && rel_len == '0, "R10 in reset");
      rst_n = 1'b1;
      @(negedge clk);
      direct_check(!rel_ack && !rel_nak && rel_len == '0, "R10 after reset");

      // R6: empty buffer
      request(1'b0, 0, "R6 empty after reset");

      // R2: fresh partial data, no idle
      rx_byte(10);
      request(1'b0, 0, "R2 partial fresh");
      // R3: 3 ticks is not enough, 4 is
      ticks(3);
      request(1'b0, 0, "R3 three ticks nak");
      ticks(1);
      request(1'b1, 10, "R3 four ticks ack");
      // R8: idle persists after release and more ticks
      request(1'b1, 10, "R8 repeat after release");
      ticks(5);
      @(negedge clk) fill_cnt = 5;
      request(1'b1, 5, "R8 smaller fill still idle");

      // R1: full packet cap, and boundaries
      rx_byte(200);
      request(1'b1, 64, "R1 fill 200 capped");
      rx_byte(64);
      request(1'b1, 64, "R1 fill 64 exact");
      rx_byte(63);
      request(1'b0, 0, "R2 fill 63 fresh nak");

      // R9: quiet cycles, length held
      repeat (4) @(negedge clk);
      direct_check(!rel_ack && !rel_nak && rel_len == LEN_W'(last_len), "R9 quiet hold");

      // R7: byte together with tick restarts measurement
      ticks(4);
      request(1'b1, 63, "R7 idle reached before restart");
      @(negedge clk);
      fill_cnt  = 20;
      byte_rx   = 1'b1;
      char_tick = 1'b1;
      @(negedge clk);
      byte_rx   = 1'b0;
      char_tick = 1'b0;
      ticks(3);
      request(1'b0, 0, "R7 byte beats tick");

      // R6: empty with idle and low latency
      ticks(2);
      @(negedge clk);
      fill_cnt   = 0;
      lowlat_set = 1'b1;
      request(1'b0, 0, "R6 empty idle lowlat");

      // R4: low-latency bit
      rx_byte(7);
      request(1'b1, 7, "R4 lowlat partial");
      @(negedge clk) lowlat_set = 1'b0;

      // R5: automatic low latency from line rate
      @(negedge clk) baud_rate = 24'd38400;
      rx_byte(9);
      request(1'b1, 9, "R5 baud below limit");
      @(negedge clk) baud_rate = 24'd40960;
      rx_byte(11);
      request(1'b0, 0, "R5 baud at limit");
      @(negedge clk) baud_rate = 24'd40959;
      request(1'b1, 11, "R5 baud one below limit");
      @(negedge clk) fill_cnt = 0;
      request(1'b0, 0, "R6 empty auto lowlat");

      repeat (3) @(negedge clk);
      direct_check(exp_q.size() == 0, "R9 all responses seen");
      finish_run();
   end

endmodule